// File: doc/BRIEF.md
# Selectable-Clock Base Timer

A free-running binary time base meant for real-time-clock housekeeping. A 14-bit counter advances once for every tick of a chosen source. The sources are a 32.768 kHz crystal tick, a tick on every system clock, or the output tick of a neighbouring timer's programmable prescaler. With the crystal source, the counter wraps every 16384 ticks, which is 500 ms. A second, shorter event comes from a carry out of a fixed intermediate bit. A two-bit select picks a period of 32, 128, 512 or 2048 ticks, which with the crystal is roughly 976 µs, 3.9 ms, 15.6 ms or 62.5 ms.

Each of the two events sets a sticky flag of its own. A one-cycle clear strobe removes the flag. The two flags feed an interrupt line that the surrounding system shares with an external interrupt input. Dropping the enable, or switching to another source, returns the counter to zero. A period measured after either action therefore starts from a clean origin.

Top module: `bt_base_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter returns to zero and both `ovf_flag` and `tap_flag` read 0 after that edge.
- R2: `src_sel` picks the counting tick: 0 = crystal tick, 1 = system tick, 2 = prescaler tick, 3 = no source (the counter holds). One selected tick with `enable` high advances the counter by exactly one.
- R3: `ovf_flag` is set on the clock edge of the 16384th counted tick after a restart, and every 16384 ticks after that (the counter wraps to zero).
- R4: `tap_flag` is set on the edge of every counted tick that brings the count to a multiple of the tap period. `tap_sel` chooses the period: 0 = 32, 1 = 128, 2 = 512, 3 = 2048 ticks (the carry out of count bit 4, 6, 8 or 10).
- R5: Both flags are sticky and independent. `clr_ovf` clears only `ovf_flag` and `clr_tap` clears only `tap_flag`, one edge after the strobe. If a new event lands on the same edge as its clear, the flag stays set.
- R6: While `enable` is low the counter is held at zero. After re-enabling, counting restarts from zero.
- R7: An edge at which `src_sel` differs from its value at the previous edge resets the counter to zero. A tick present in that cycle is not counted.
- R8: Ticks on sources that `src_sel` does not select have no effect on the count or the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_tick | input | 1 | One-cycle tick from the 32.768 kHz crystal domain (source 0) |
| sys_tick | input | 1 | System-clock tick enable (source 1) |
| pre_tick | input | 1 | Tick from the programmable prescaler of the multi-mode timer (source 2) |
| src_sel | input | 2 | Clock source select |
| tap_sel | input | 2 | Short-period tap select |
| enable | input | 1 | Count enable; low holds the counter at zero |
| clr_ovf | input | 1 | Clear strobe for the overflow flag |
| clr_tap | input | 1 | Clear strobe for the tap flag |
| ovf_flag | output | 1 | Sticky full-wrap event flag |
| tap_flag | output | 1 | Sticky selected-tap event flag |

## Verification
The bench builds the block with its default parameters: a 14-bit counter, taps starting at bit 4 and spaced two bits apart, and four taps. Because a source can tick on every clock, a full 16384-tick wrap with eight 2048-tick tap events along the way fits in a short run. The crystal and prescaler paths are driven at sparser tick rates while the unselected sources toggle at random. Every flag event is predicted from a tick count kept in the bench and compared against the cycle in which the flag appears, which makes restarts by source change and by disable visible as shifted event times.

// File: rtl/bt_pkg.sv
// Shared definitions for the base timer.
// Assumes the source select is two bits wide with one reserved code.
package bt_pkg;
    typedef enum logic [1:0] {
        SRC_XTAL = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_PRE  = 2'd2,
        SRC_NONE = 2'd3
    } bt_src_e;
endpackage

// File: rtl/bt_src_mux.sv
// Picks the tick of the selected clock source.
// Assumes each tick input is already a one-cycle enable in the clk domain.
module bt_src_mux
    import bt_pkg::*;
(
    input  logic    xtal_tick,
    input  logic    sys_tick,
    input  logic    pre_tick,
    input  bt_src_e src_sel,
    output logic    tick_o
);
    // route the chosen source; the reserved code never ticks
    always_comb begin
        unique case (src_sel)
            SRC_XTAL: tick_o = xtal_tick;
            SRC_SYS:  tick_o = sys_tick;
            SRC_PRE:  tick_o = pre_tick;
            default:  tick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bt_counter.sv
// Free-running binary counter with per-bit carry outputs.
// Restarts from zero when disabled or when the source select changes.
// Assumes src_sel is registered by the caller's domain (synchronous to clk).
module bt_counter
    import bt_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  bt_src_e          src_sel,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] carry_o
);
    bt_src_e src_q;
    logic    restart;
    logic    advance;

    assign restart = !enable || (src_sel != src_q);
    assign advance = tick && !restart;

    // ripple carry chain: carry_o[i] is the carry out of bit i on this tick
    assign carry_o[0] = advance & cnt_q[0];
    for (genvar i = 1; i < CNT_W; i++) begin : g_carry
        assign carry_o[i] = carry_o[i-1] & cnt_q[i];
    end

    // remember the source seen at the previous edge
    always_ff @(posedge clk) begin
        src_q <= src_sel;
    end

    // count selected ticks, restart to zero on disable or source change
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bt_flags.sv
// Turns carry outputs into the full-wrap and selected-tap sticky flags.
// Tap k is the carry out of bit TAP_BASE + TAP_STEP*k.
// Assumes the last tap bit lies inside the counter.
module bt_flags #(
    parameter int CNT_W    = 14,
    parameter int TAP_BASE = 4,
    parameter int TAP_STEP = 2,
    parameter int TAP_N    = 4,
    localparam int TAP_SEL_W = (TAP_N > 1) ? $clog2(TAP_N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     carry,
    input  logic [TAP_SEL_W-1:0] tap_sel,
    input  logic                 clr_ovf,
    input  logic                 clr_tap,
    output logic                 ovf_flag,
    output logic                 tap_flag
);
    logic [TAP_N-1:0] tap_evt;
    logic             tap_hit;
    logic             ovf_hit;

    for (genvar k = 0; k < TAP_N; k++) begin : g_tap
        assign tap_evt[k] = carry[TAP_BASE + TAP_STEP*k];
    end

    assign tap_hit = tap_evt[tap_sel];
    assign ovf_hit = carry[CNT_W-1];

    // sticky flags: a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            tap_flag <= 1'b0;
        end else begin
            ovf_flag <= ovf_hit | (ovf_flag & ~clr_ovf);
            tap_flag <= tap_hit | (tap_flag & ~clr_tap);
        end
    end
endmodule

// File: rtl/bt_base_timer.sv
// Base timer top: source select, counter and event flags.
// Assumes all tick inputs are synchronous one-cycle enables.
module bt_base_timer
    import bt_pkg::*;
#(
    parameter int CNT_W    = 14,
    parameter int TAP_BASE = 4,
    parameter int TAP_STEP = 2,
    parameter int TAP_N    = 4,
    localparam int TAP_SEL_W = (TAP_N > 1) ? $clog2(TAP_N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xtal_tick,
    input  logic                 sys_tick,
    input  logic                 pre_tick,
    input  logic [1:0]           src_sel,
    input  logic [TAP_SEL_W-1:0] tap_sel,
    input  logic                 enable,
    input  logic                 clr_ovf,
    input  logic                 clr_tap,
    output logic                 ovf_flag,
    output logic                 tap_flag
);
    bt_src_e          src_e;
    logic             tick_sel;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] carry;

    assign src_e = bt_src_e'(src_sel);

    bt_src_mux u_mux (
        .xtal_tick (xtal_tick),
        .sys_tick  (sys_tick),
        .pre_tick  (pre_tick),
        .src_sel   (src_e),
        .tick_o    (tick_sel)
    );

    bt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .src_sel (src_e),
        .tick    (tick_sel),
        .cnt_q   (cnt_q),
        .carry_o (carry)
    );

    bt_flags #(
        .CNT_W    (CNT_W),
        .TAP_BASE (TAP_BASE),
        .TAP_STEP (TAP_STEP),
        .TAP_N    (TAP_N)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .carry    (carry),
        .tap_sel  (tap_sel),
        .clr_ovf  (clr_ovf),
        .clr_tap  (clr_tap),
        .ovf_flag (ovf_flag),
        .tap_flag (tap_flag)
    );
endmodule

// File: rtl/bt_base_timer_chk.sv
// Property checker for the base timer, attached by bind.
// Observes ports plus the selected tick and the count register.
module bt_base_timer_chk #(
    parameter int CNT_W    = 14,
    parameter int TAP_BASE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [1:0]       src_sel,
    input logic             tick_sel,
    input logic [CNT_W-1:0] cnt,
    input logic             clr_ovf,
    input logic             clr_tap,
    input logic             ovf_flag,
    input logic             tap_flag
);
    // R1
    rst_flags_chk: assert property (@(posedge clk)
        !rst_n |=> (!ovf_flag && !tap_flag && cnt == '0));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $stable(src_sel) && tick_sel) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $stable(src_sel) && !tick_sel) |=> $stable(cnt));

    // R3
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> cnt == '0);

    // R4
    tap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tap_flag) |-> cnt[TAP_BASE:0] == '0);

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    // R5
    tap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_flag && !clr_tap) |=> tap_flag);

    // R6
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> cnt == '0);

    // R7
    src_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_sel) |=> cnt == '0);
endmodule

bind bt_base_timer bt_base_timer_chk #(
    .CNT_W    (CNT_W),
    .TAP_BASE (TAP_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .src_sel  (src_sel),
    .tick_sel (tick_sel),
    .cnt      (cnt_q),
    .clr_ovf  (clr_ovf),
    .clr_tap  (clr_tap),
    .ovf_flag (ovf_flag),
    .tap_flag (tap_flag)
);

// File: tb/tb_bt_base_timer.sv
// Scoreboard bench: the driver predicts flag events into queues,
// the monitor pops them as flags appear and clears the flags.
module tb_bt_base_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xtal_tick = 1'b0, sys_tick = 1'b0, pre_tick = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [1:0] tap_sel = 2'd0;
    logic       enable = 1'b0;
    logic       clr_ovf = 1'b0, clr_tap = 1'b0;
    logic       ovf_flag, tap_flag;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int mcount = 0;
    logic [1:0] prev_src = 2'd0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    string tag = "R1";
    int tap_q[$];
    int ovf_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bt_base_timer dut (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .sys_tick(sys_tick),
        .pre_tick(pre_tick), .src_sel(src_sel), .tap_sel(tap_sel),
        .enable(enable), .clr_ovf(clr_ovf), .clr_tap(clr_tap),
        .ovf_flag(ovf_flag), .tap_flag(tap_flag)
    );

    function automatic int tap_period(logic [1:0] t);
        case (t)
            2'd0: return 32;
            2'd1: return 128;
            2'd2: return 512;
            default: return 2048;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one cycle of inputs and predict the events it causes
    task automatic drive(input logic x, input logic s, input logic p,
                         input logic [1:0] src, input logic en);
        logic t;
        xtal_tick = x; sys_tick = s; pre_tick = p;
        src_sel = src; enable = en;
        case (src)
            2'd0: t = x;
            2'd1: t = s;
            2'd2: t = p;
            default: t = 1'b0;
        endcase
        if (!en || src != prev_src) mcount = 0;
        else if (t) begin
            mcount++;
            if (mcount % tap_period(tap_sel) == 0) tap_q.push_back(cyc + 1);
            if (mcount % 16384 == 0) ovf_q.push_back(cyc + 1);
        end
        prev_src = src;
        @(negedge clk);
    endtask

    // n selected ticks spaced gap cycles apart, unselected sources random
    task automatic run(input logic [1:0] src, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            for (int g = 0; g < gap; g++) begin
                logic sel;
                logic x, s, p;
                sel = (g == gap - 1);
                x = (src == 2'd0) ? sel : 1'($urandom);
                s = (src == 2'd1) ? sel : 1'($urandom);
                p = (src == 2'd2) ? sel : 1'($urandom);
                drive(x, s, p, src, 1'b1);
            end
        end
    endtask

    // monitor: compare each flag appearance with the predicted cycle
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (tap_flag) begin
                    if (tap_q.size() == 0) check({tag, " R4 unexpected tap"}, cyc, -1);
                    else check({tag, " R4 tap event cycle"}, cyc, tap_q.pop_front());
                end
                if (ovf_flag) begin
                    if (ovf_q.size() == 0) check({tag, " R3 unexpected wrap"}, cyc, -1);
                    else check({tag, " R3 wrap event cycle"}, cyc, ovf_q.pop_front());
                end
                clr_tap = tap_flag;
                clr_ovf = ovf_flag;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R1 ovf_flag after reset", int'(ovf_flag), 0);
        check("R1 tap_flag after reset", int'(tap_flag), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // system source, tap 32, then tap 128 without restart; noise on others
        tag = "R2 R8";
        tap_sel = 2'd0;
        drive(0, 0, 0, 2'd1, 1'b1);
        run(2'd1, 200, 1);
        tap_sel = 2'd1;
        run(2'd1, 300, 1);

        // disable restarts; crystal source, tap 512
        tag = "R6";
        drive(0, 0, 0, 2'd1, 1'b0);
        drive(0, 0, 0, 2'd1, 1'b0);
        tap_sel = 2'd2;
        drive(1, 0, 0, 2'd0, 1'b1);
        run(2'd0, 1100, 3);

        // source change with a tick in the change cycle restarts from zero
        tag = "R7";
        tap_sel = 2'd3;
        drive(0, 0, 1, 2'd2, 1'b1);
        run(2'd2, 2100, 2);

        // full wrap with the system source
        tag = "R3";
        drive(0, 0, 0, 2'd1, 1'b0);
        run(2'd1, 16384 + 60, 1);

        // reserved source: nothing counts
        tag = "R2 reserved";
        drive(1, 1, 1, 2'd3, 1'b1);
        for (int i = 0; i < 3000; i++) drive(1, 1, 1, 2'd3, 1'b1);
        repeat (3) @(negedge clk);
        check("R3 R4 all predicted events seen", tap_q.size() + ovf_q.size(), 0);

        // directed flag behaviour with the monitor off
        mon_on = 1'b0;
        @(negedge clk);
        clr_tap = 1'b0; clr_ovf = 1'b0;
        tap_sel = 2'd0;
        drive(0, 0, 0, 2'd1, 1'b0);
        for (int i = 0; i < 32; i++) drive(0, 1, 0, 2'd1, 1'b1);
        check("R4 tap at 32nd tick", int'(tap_flag), 1);
        for (int i = 0; i < 5; i++) drive(0, 0, 0, 2'd1, 1'b1);
        check("R5 tap flag sticky", int'(tap_flag), 1);
        check("R5 ovf flag independent", int'(ovf_flag), 0);
        clr_ovf = 1'b1;
        drive(0, 0, 0, 2'd1, 1'b1);
        clr_ovf = 1'b0;
        check("R5 clr_ovf leaves tap flag", int'(tap_flag), 1);
        clr_tap = 1'b1;
        drive(0, 0, 0, 2'd1, 1'b1);
        clr_tap = 1'b0;
        check("R5 clr_tap clears", int'(tap_flag), 0);
        for (int i = 0; i < 31; i++) drive(0, 1, 0, 2'd1, 1'b1);
        check("R4 no tap at 63", int'(tap_flag), 0);
        clr_tap = 1'b1;
        drive(0, 1, 0, 2'd1, 1'b1);
        clr_tap = 1'b0;
        check("R5 set wins over clear", int'(tap_flag), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule